// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns one character at a time into an asynchronous serial frame on a single output line. A producer offers a character of up to nine bits on a valid/ready handshake. The block stores it and, once the transmitter is enabled, sends it. The frame is a low start bit, the data bits least significant first, an optional parity bit, and one or two high stop bits. The line rests high between frames.

The frame format and the bit rate come from a set of static configuration fields:

- a two-bit word-length code;
- parity enable and parity type;
- a two-bit stop code;
- a 16-bit baud divisor;
- an oversampling select that re-packs the divisor.

The block decodes these fields together at the start of every frame. If any field holds an unsupported value, the whole set is rejected and the previous format and rate stay in force. Two status outputs report that the holding register is empty and that the last frame has been fully sent. The empty output also serves as the ready signal of the input handshake.

Top module: `uartFrameTx`

## Requirements
- R1: The word-length code `wordLenCode` selects 8 data bits for 2'b00, 9 data bits for 2'b01 and 7 data bits for 2'b10.
- R2: When `parityEn` is 1, a parity bit follows the data. With `parityOdd` = 1 the data bits and the parity bit together hold an odd number of ones; with `parityOdd` = 0 they hold an even number. When `parityEn` is 0, no parity bit is sent.
- R3: The stop code `stopCode` selects one stop bit for 2'b00 and two stop bits for 2'b10.
- R4: The configuration set is rejected as a whole, and the last accepted format and rate are kept, in any of these cases: `wordLenCode` is 2'b11, `stopCode` is 2'b01 or 2'b11, or `baudDiv` is below 16. After reset the kept setting is 8 data bits, no parity, one stop bit and a 16-cycle bit period.
- R5: With `overSample8` = 0, every bit of the frame lasts `baudDiv` clock cycles.
- R6: With `overSample8` = 1, every bit lasts P clock cycles. P is the value built from `baudDiv[15:4]` in place and `baudDiv[2:0]` shifted left by one, with `baudDiv[3]` ignored, then divided by two.
- R7: `txLine` is 1 while idle. A frame is one low start bit, then the data bits LSB first, then the parity bit if enabled, then high stop bits.
- R8: A frame starts only while `txEnable` is 1 and a character is held. A character accepted while `txEnable` is 0 is kept, and the line stays high, until the enable is set.
- R9: `txEmpty` and `txDone` are both 1 after reset. Both fall when a character is accepted (`txValid` while `txEmpty`). Both rise together on the clock edge that ends the last stop bit.
- R10: The configuration inputs are sampled in the cycle a frame starts. Changes made during a frame affect only later frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wordLenCode | input | 2 | Word-length code (R1) |
| parityEn | input | 1 | Adds a parity bit when 1 |
| parityOdd | input | 1 | Parity type: 1 odd, 0 even |
| stopCode | input | 2 | Stop-bit code (R3) |
| overSample8 | input | 1 | Selects 8x oversampling divisor packing |
| baudDiv | input | 16 | Baud divisor field |
| txEnable | input | 1 | Transmitter enable |
| txData | input | 9 | Character to send; bits above the word length are ignored |
| txValid | input | 1 | Character offered on `txData` |
| txEmpty | output | 1 | Holding register empty; also the handshake ready |
| txDone | output | 1 | Last accepted character fully sent |
| txLine | output | 1 | Serial output line |

## Verification
Two things can fall in the same span of time: the frame in flight is still being serialised while a new configuration arrives on the inputs. The bench provokes this by rewriting the divisor and the word-length code about two bit periods into a frame. It checks every clock cycle of that frame against the old period and bit count. It then checks the next frame, bit by bit, against the new setting. A second overlap is a character accepted while the transmitter is disabled. The bench judges that case by the line staying high and both status outputs staying low until the enable arrives, and by the frame that follows it.

// File: rtl/uartTxPkg.sv
package uartTxPkg;

  localparam int DIV_W = 16;
  localparam int DATA_W = 9;
  localparam int CNT_W = 4;
  localparam int MIN_DIV = 16;

  typedef struct packed {
    logic [CNT_W-1:0] dataBits;
    logic parEn;
    logic parOdd;
    logic [1:0] stopBits;
    logic [DIV_W-1:0] period;
  } frameCfg_t;

  typedef struct packed {
    logic loadBuf;
    logic startFrame;
    logic emitData;
    logic emitParity;
    logic emitStop;
  } txStrobe_t;

  localparam frameCfg_t RESET_CFG = '{
    dataBits: CNT_W'(8),
    parEn: 1'b0,
    parOdd: 1'b0,
    stopBits: 2'd1,
    period: DIV_W'(16)
  };

  // Decodes the raw fields; any invalid field keeps the previous set whole.
  function automatic frameCfg_t decodeCfg(
    input logic [1:0] wlCode,
    input logic pe,
    input logic po,
    input logic [1:0] stCode,
    input logic ov8,
    input logic [DIV_W-1:0] div,
    input frameCfg_t prev
  );
    frameCfg_t c;
    logic ok;
    logic [DIV_W-1:0] packed8;
    ok = 1'b1;
    c = prev;
    case (wlCode)
      2'b00: c.dataBits = CNT_W'(8);
      2'b01: c.dataBits = CNT_W'(9);
      2'b10: c.dataBits = CNT_W'(7);
      default: ok = 1'b0;
    endcase
    case (stCode)
      2'b00: c.stopBits = 2'd1;
      2'b10: c.stopBits = 2'd2;
      default: ok = 1'b0;
    endcase
    if (div < DIV_W'(MIN_DIV)) ok = 1'b0;
    packed8 = {div[DIV_W-1:4], 4'b0000} | {{(DIV_W-4){1'b0}}, div[2:0], 1'b0};
    c.period = ov8 ? (packed8 >> 1) : div;
    c.parEn = pe;
    c.parOdd = po;
    return ok ? c : prev;
  endfunction

endpackage

// File: rtl/uartTxDatapath.sv
module uartTxDatapath
  import uartTxPkg::*;
#(
  parameter int DATA_W_P = DATA_W,
  parameter int DIV_W_P = DIV_W
) (
  input  logic clk,
  input  logic rstN,
  input  txStrobe_t strobe,
  input  logic [1:0] wordLenCode,
  input  logic parityEn,
  input  logic parityOdd,
  input  logic [1:0] stopCode,
  input  logic overSample8,
  input  logic [DIV_W_P-1:0] baudDiv,
  input  logic [DATA_W_P-1:0] txData,
  output frameCfg_t cfg,
  output logic bitEnd,
  output logic txLine
);

  frameCfg_t cfgQ, cfgNext;
  logic [DATA_W_P-1:0] bufQ, shiftQ, dataMask, maskedBuf;
  logic [DIV_W_P-1:0] baudCnt;
  logic parBitQ, lineQ;

  assign cfgNext = decodeCfg(wordLenCode, parityEn, parityOdd, stopCode,
                             overSample8, baudDiv, cfgQ);

  always_comb begin
    for (int i = 0; i < DATA_W_P; i++) begin
      dataMask[i] = (i < int'(cfgNext.dataBits));
    end
  end

  assign maskedBuf = bufQ & dataMask;
  assign bitEnd = (baudCnt == '0);
  assign cfg = cfgQ;
  assign txLine = lineQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= RESET_CFG;
      bufQ <= '0;
      shiftQ <= '0;
      parBitQ <= 1'b0;
      lineQ <= 1'b1;
      baudCnt <= '0;
    end else begin
      if (strobe.loadBuf) bufQ <= txData;
      if (strobe.startFrame) begin
        cfgQ <= cfgNext;
        shiftQ <= maskedBuf;
        parBitQ <= (^maskedBuf) ^ cfgNext.parOdd;
        lineQ <= 1'b0;
        baudCnt <= cfgNext.period - 1'b1;
      end else begin
        if (bitEnd) baudCnt <= cfgQ.period - 1'b1;
        else baudCnt <= baudCnt - 1'b1;
        if (strobe.emitData) begin
          lineQ <= shiftQ[0];
          shiftQ <= shiftQ >> 1;
        end else if (strobe.emitParity) begin
          lineQ <= parBitQ;
        end else if (strobe.emitStop) begin
          lineQ <= 1'b1;
        end
      end
    end
  end

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rstN)
    strobe.startFrame |=> !txLine); // R7
  AST_STOP_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    strobe.emitStop |=> txLine); // R7
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.startFrame |=> $stable(cfgQ)); // R10
  AST_PERIOD_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    cfgQ.period >= DIV_W_P'(8)); // R4

endmodule

// File: rtl/uartTxCtrl.sv
module uartTxCtrl
  import uartTxPkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic txValid,
  input  logic txEnable,
  input  frameCfg_t cfg,
  input  logic bitEnd,
  output txStrobe_t strobe,
  output logic txEmpty,
  output logic txDone
);

  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP} txState_t;

  txState_t state, stateNext;
  logic [CNT_W-1:0] bitCnt, bitCntNext;
  logic pendingQ, emptyQ, doneQ, accept, finish;

  assign accept = txValid & emptyQ;
  assign txEmpty = emptyQ;
  assign txDone = doneQ;

  always_comb begin
    strobe = '0;
    stateNext = state;
    bitCntNext = bitCnt;
    finish = 1'b0;
    strobe.loadBuf = accept;
    case (state)
      ST_IDLE: if (pendingQ && txEnable) begin
        strobe.startFrame = 1'b1;
        stateNext = ST_START;
      end
      ST_START: if (bitEnd) begin
        strobe.emitData = 1'b1;
        bitCntNext = CNT_W'(1);
        stateNext = ST_DATA;
      end
      ST_DATA: if (bitEnd) begin
        if (bitCnt == cfg.dataBits) begin
          bitCntNext = CNT_W'(1);
          if (cfg.parEn) begin
            strobe.emitParity = 1'b1;
            stateNext = ST_PAR;
          end else begin
            strobe.emitStop = 1'b1;
            stateNext = ST_STOP;
          end
        end else begin
          strobe.emitData = 1'b1;
          bitCntNext = bitCnt + 1'b1;
        end
      end
      ST_PAR: if (bitEnd) begin
        strobe.emitStop = 1'b1;
        bitCntNext = CNT_W'(1);
        stateNext = ST_STOP;
      end
      ST_STOP: if (bitEnd) begin
        if (bitCnt == CNT_W'(cfg.stopBits)) begin
          finish = 1'b1;
          stateNext = ST_IDLE;
        end else begin
          bitCntNext = bitCnt + 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      bitCnt <= '0;
      pendingQ <= 1'b0;
      emptyQ <= 1'b1;
      doneQ <= 1'b1;
    end else begin
      state <= stateNext;
      bitCnt <= bitCntNext;
      if (accept) pendingQ <= 1'b1;
      else if (strobe.startFrame) pendingQ <= 1'b0;
      if (accept) begin
        emptyQ <= 1'b0;
        doneQ <= 1'b0;
      end else if (finish) begin
        emptyQ <= 1'b1;
        doneQ <= 1'b1;
      end
    end
  end

  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !txEnable) |=> state == ST_IDLE); // R8
  AST_DONE_WITH_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneQ) |-> $rose(emptyQ)); // R9
  AST_BUSY_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    state != ST_IDLE |-> !emptyQ); // R9
  AST_ONE_EMIT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.startFrame, strobe.emitData, strobe.emitParity, strobe.emitStop})); // R7

endmodule

// File: rtl/uartFrameTx.sv
module uartFrameTx
  import uartTxPkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic [1:0] wordLenCode,
  input  logic parityEn,
  input  logic parityOdd,
  input  logic [1:0] stopCode,
  input  logic overSample8,
  input  logic [15:0] baudDiv,
  input  logic txEnable,
  input  logic [8:0] txData,
  input  logic txValid,
  output logic txEmpty,
  output logic txDone,
  output logic txLine
);

  txStrobe_t strobe;
  frameCfg_t cfg;
  logic bitEnd;

  uartTxCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .txValid(txValid), .txEnable(txEnable),
    .cfg(cfg), .bitEnd(bitEnd), .strobe(strobe),
    .txEmpty(txEmpty), .txDone(txDone)
  );

  uartTxDatapath #(.DATA_W_P(DATA_W), .DIV_W_P(DIV_W)) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .wordLenCode(wordLenCode), .parityEn(parityEn), .parityOdd(parityOdd),
    .stopCode(stopCode), .overSample8(overSample8), .baudDiv(baudDiv),
    .txData(txData), .cfg(cfg), .bitEnd(bitEnd), .txLine(txLine)
  );

endmodule

// File: tb/test_uartFrameTx.sv
`timescale 1ns/1ps
module test_uartFrameTx;

  typedef struct packed {
    logic [1:0] wl;
    logic pe;
    logic po;
    logic [1:0] st;
    logic ov8;
    logic [15:0] div;
    logic [8:0] data;
    logic [3:0] eBits;
    logic ePe;
    logic ePo;
    logic [1:0] eStops;
    logic [15:0] eP;
  } vec_t;

  // R1/R2/R3/R5/R6 vectors: fields, data, expected bits/parity/stops/period
  localparam int NVEC = 5;
  localparam vec_t VECS [NVEC] = '{
    '{2'b00, 1'b0, 1'b0, 2'b00, 1'b0, 16'd16, 9'h05A, 4'd8, 1'b0, 1'b0, 2'd1, 16'd16},
    '{2'b01, 1'b1, 1'b0, 2'b10, 1'b0, 16'd20, 9'h1A5, 4'd9, 1'b1, 1'b0, 2'd2, 16'd20},
    '{2'b10, 1'b1, 1'b1, 2'b00, 1'b1, 16'h0025, 9'h153, 4'd7, 1'b1, 1'b1, 2'd1, 16'd21},
    '{2'b00, 1'b1, 1'b1, 2'b10, 1'b1, 16'h001F, 9'h0FF, 4'd8, 1'b1, 1'b1, 2'd2, 16'd15},
    '{2'b00, 1'b0, 1'b0, 2'b10, 1'b0, 16'd17, 9'h000, 4'd8, 1'b0, 1'b0, 2'd2, 16'd17}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] wordLenCode = 2'b00;
  logic parityEn = 1'b0, parityOdd = 1'b0, overSample8 = 1'b0;
  logic [1:0] stopCode = 2'b00;
  logic [15:0] baudDiv = 16'd0;
  logic txEnable = 1'b1;
  logic [8:0] txData = '0;
  logic txValid = 1'b0;
  logic txEmpty, txDone, txLine;
  int nRun = 0;
  int nFail = 0;

  always #2.5 clk = ~clk;

  uartFrameTx i_uartFrameTx (
    .clk(clk), .rstN(rstN), .wordLenCode(wordLenCode), .parityEn(parityEn),
    .parityOdd(parityOdd), .stopCode(stopCode), .overSample8(overSample8),
    .baudDiv(baudDiv), .txEnable(txEnable), .txData(txData), .txValid(txValid),
    .txEmpty(txEmpty), .txDone(txDone), .txLine(txLine)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic applyCfg(input vec_t v);
    wordLenCode = v.wl; parityEn = v.pe; parityOdd = v.po;
    stopCode = v.st; overSample8 = v.ov8; baudDiv = v.div;
  endtask

  task automatic sendChar(input logic [8:0] d);
    int guard = 0;
    while (!txEmpty && guard < 5000) begin @(negedge clk); guard++; end
    txData = d; txValid = 1'b1;
    @(negedge clk);
    txValid = 1'b0;
  endtask

  task automatic checkFrame(input vec_t v, input string tag);
    logic [15:0] fr;
    logic [8:0] m;
    int n, p, bad, guard, firstBad, firstAct, firstExp;
    bit emptyOk, doneOk;
    m = 9'((1 << v.eBits) - 1);
    fr = '1;
    fr[0] = 1'b0;
    for (int i = 0; i < int'(v.eBits); i++) fr[1 + i] = v.data[i];
    if (v.ePe) fr[1 + v.eBits] = (^(v.data & m)) ^ v.ePo;
    n = 1 + int'(v.eBits) + int'(v.ePe) + int'(v.eStops);
    p = int'(v.eP);
    guard = 0;
    while (txLine && guard < 3000) begin @(negedge clk); guard++; end
    bad = 0; firstBad = -1; firstAct = 0; firstExp = 0;
    emptyOk = 1'b1; doneOk = 1'b1;
    for (int off = 0; off <= n * p; off++) begin
      if (off < n * p) begin
        if (txLine !== fr[off / p]) begin
          if (firstBad < 0) begin
            firstBad = off; firstAct = int'(txLine); firstExp = int'(fr[off / p]);
          end
          bad++;
        end
        if (off == n * p - 1) emptyOk = (txEmpty === 1'b0);
        @(negedge clk);
      end else begin
        doneOk = (txEmpty === 1'b1) && (txDone === 1'b1);
      end
    end
    chk(bad == 0 && guard < 3000, "R1/R2/R3/R5/R6/R7",
        $sformatf("%s line bit at cycle %0d", tag, firstBad), firstAct, firstExp);
    chk(emptyOk && doneOk, "R9", $sformatf("%s empty/done at frame end", tag),
        int'({txEmpty, txDone}), 3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nRun + 1, nFail);
    $finish;
  end

  initial begin
    vec_t v;
    int lineBad;
    repeat (3) @(negedge clk);
    chk(txLine === 1'b1, "R7", "idle line after reset", int'(txLine), 1);
    chk(txEmpty === 1'b1 && txDone === 1'b1, "R9", "status after reset",
        int'({txEmpty, txDone}), 3);
    rstN = 1'b1;
    @(negedge clk);

    // R4: invalid divisor straight after reset keeps 8N1 at 16 cycles
    v = '{2'b01, 1'b1, 1'b0, 2'b10, 1'b0, 16'd0, 9'h0C3, 4'd8, 1'b0, 1'b0, 2'd1, 16'd16};
    applyCfg(v); sendChar(v.data); checkFrame(v, "R4 reset default");

    for (int k = 0; k < NVEC; k++) begin
      applyCfg(VECS[k]);
      sendChar(VECS[k].data);
      checkFrame(VECS[k], $sformatf("vector %0d", k));
    end

    // R4: invalid word length, stop code, divisor each keep 8N2 at 17
    v = '{2'b11, 1'b1, 1'b1, 2'b00, 1'b0, 16'd40, 9'h0A6, 4'd8, 1'b0, 1'b0, 2'd2, 16'd17};
    applyCfg(v); sendChar(v.data); checkFrame(v, "R4 word code 11");
    v = '{2'b10, 1'b1, 1'b0, 2'b01, 1'b0, 16'd40, 9'h03C, 4'd8, 1'b0, 1'b0, 2'd2, 16'd17};
    applyCfg(v); sendChar(v.data); checkFrame(v, "R4 stop code 01");
    v = '{2'b01, 1'b0, 1'b0, 2'b00, 1'b0, 16'd15, 9'h1E1, 4'd8, 1'b0, 1'b0, 2'd2, 16'd17};
    applyCfg(v); sendChar(v.data); checkFrame(v, "R4 divisor 15");

    // R8: character held while disabled; line stays high
    v = '{2'b00, 1'b0, 1'b0, 2'b00, 1'b0, 16'd16, 9'h0B2, 4'd8, 1'b0, 1'b0, 2'd1, 16'd16};
    applyCfg(v);
    txEnable = 1'b0;
    sendChar(v.data);
    lineBad = 0;
    for (int c = 0; c < 100; c++) begin
      if (txLine !== 1'b1) lineBad++;
      @(negedge clk);
    end
    chk(lineBad == 0, "R8", "line high while disabled", lineBad, 0);
    chk(txEmpty === 1'b0 && txDone === 1'b0, "R9", "status cleared by accept",
        int'({txEmpty, txDone}), 0);
    txEnable = 1'b1;
    checkFrame(v, "R8 after enable");

    // R10: mid-frame change must not touch the current frame
    v = '{2'b00, 1'b1, 1'b0, 2'b00, 1'b0, 16'd16, 9'h069, 4'd8, 1'b1, 1'b0, 2'd1, 16'd16};
    applyCfg(v); sendChar(v.data);
    fork
      checkFrame(v, "R10 current frame");
      begin
        repeat (40) @(negedge clk);
        baudDiv = 16'd30; wordLenCode = 2'b01;
      end
    join
    v = '{2'b01, 1'b1, 1'b0, 2'b00, 1'b0, 16'd30, 9'h155, 4'd9, 1'b1, 1'b0, 2'd1, 16'd30};
    sendChar(v.data); checkFrame(v, "R10 next frame");

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule